// File: doc/BRIEF.md
# Fetch Address Sequencer with Wrapping Return Stack

This block holds the 13-bit program counter of a small accumulator CPU and selects its next value each clock. The counter can step by one, jump to the interrupt entry, take an absolute jump or call, return through a hardware stack, or load its low byte from an ALU result. The high bits come from a separate latch value in two ways. A low-byte write takes five latch bits. An absolute jump or call takes only the top two latch bits, above an 11-bit opcode target.

Calls and interrupt entries push a return address onto an eight-entry stack with no overflow or underflow detection. The stack pointer counts modulo the depth in both directions, so deep nesting silently overwrites the oldest entries. A pop from an empty stack silently reads the top slot. The fetch address sent to program memory keeps only the implemented low bits of the counter. Decoding, the ALU and the program memory sit outside this block and only drive its single-cycle strobes.

Top module: `pc_seq_top`

## Requirements
- R1: An asynchronous reset (rst_ni low) clears the PC, the stack pointer and all eight stack entries to zero.
- R2: With only inc_i set, the PC advances by one each cycle, and 0x1FFF wraps to 0x0000. With no strobe set, the PC holds.
- R3: irq_i pushes the current PC, not PC+1, and loads the PC with 0x0004.
- R4: jump_i loads PC[10:0] from target_i and PC[12:11] from latch_i[4:3], with no stack change.
- R5: call_i loads the PC as in R4 and pushes the old PC plus one.
- R6: ret_i loads the PC with the most recently pushed entry that has not yet been popped, and moves the pointer back by one.
- R7: pcl_wr_i loads PC[7:0] from alu_i and PC[12:8] from latch_i[4:0].
- R8: The stack pointer wraps modulo 8 on push. After nine pushes a0..a8, successive pops return a8, a7, ..., a1, and then a8 again.
- R9: A pop with nothing pushed wraps the pointer downward without saturating. Right after reset it returns 0x0000, and the following push lands in that same slot.
- R10: When strobes coincide, the priority is irq_i, then call_i or jump_i (call_i wins and pushes), then ret_i, then pcl_wr_i, then inc_i. Only the winning action affects the PC and the stack.
- R11: fetch_addr_o equals PC[10:0], with bits [12:11] forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inc_i | input | 1 | Step PC by one |
| pcl_wr_i | input | 1 | Load the low PC byte from the ALU |
| jump_i | input | 1 | Absolute jump |
| call_i | input | 1 | Absolute call with push |
| ret_i | input | 1 | Pop into the PC |
| irq_i | input | 1 | Branch to the interrupt entry with push |
| latch_i | input | 5 | High-bit latch value |
| alu_i | input | 8 | ALU result for low-byte writes |
| target_i | input | 11 | Opcode jump target |
| pc_o | output | 13 | Current PC |
| fetch_addr_o | output | 13 | PC folded into the implemented memory |

## Verification
A wrong stack pointer or a corrupted entry stays invisible until a later return, which can come many cycles after the fault. The bench therefore nests calls past the depth and unwinds them fully, and it pops right after reset. This exposes an off-by-one in the pointer or the saved address on the first return that reads the affected slot. Faults in priority or in the high-bit source appear on pc_o one cycle after the conflicting strobes. The bench compares the PC in every cycle, so they are caught at once.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int PC_W      = 13;
  localparam int OPC_W     = 11;
  localparam int LAT_W     = 5;
  localparam int DATA_W    = 8;
  localparam int STK_DEPTH = 8;
  localparam int IMPL_W    = 11;
  localparam logic [PC_W-1:0] IRQ_VEC = 13'h0004;

  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_INC,
    SEL_PCL,
    SEL_RET,
    SEL_JMP,
    SEL_CALL,
    SEL_IRQ
  } sel_e;
endpackage

// File: rtl/pc_sel_arb.sv
module pc_sel_arb
  import pcs_pkg::*;
(
  input  logic inc_i,
  input  logic pcl_wr_i,
  input  logic jump_i,
  input  logic call_i,
  input  logic ret_i,
  input  logic irq_i,
  output sel_e sel_o,
  output logic push_o,
  output logic pop_o
);
  always_comb begin
    if (irq_i)         sel_o = SEL_IRQ;
    else if (call_i)   sel_o = SEL_CALL;
    else if (jump_i)   sel_o = SEL_JMP;
    else if (ret_i)    sel_o = SEL_RET;
    else if (pcl_wr_i) sel_o = SEL_PCL;
    else if (inc_i)    sel_o = SEL_INC;
    else               sel_o = SEL_HOLD;
  end

  assign push_o = (sel_o == SEL_IRQ) || (sel_o == SEL_CALL);
  assign pop_o  = (sel_o == SEL_RET);
endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
  import pcs_pkg::*;
#(
  parameter int W   = PC_W,
  parameter int OW  = OPC_W,
  parameter int LW  = LAT_W,
  parameter int DW  = DATA_W
) (
  input  sel_e          sel_i,
  input  logic [W-1:0]  pc_i,
  input  logic [LW-1:0] latch_i,
  input  logic [DW-1:0] alu_i,
  input  logic [OW-1:0] target_i,
  input  logic [W-1:0]  stk_top_i,
  output logic [W-1:0]  nxt_o,
  output logic [W-1:0]  push_data_o
);
  localparam int HI_JMP = W - OW;
  localparam int HI_PCL = W - DW;

  logic [W-1:0] pc_inc;
  logic [W-1:0] jmp_pc;
  logic [W-1:0] pcl_pc;

  assign pc_inc = pc_i + W'(1);
  // Absolute jumps take only the top latch bits above the target field.
  assign jmp_pc = {latch_i[LW-1 -: HI_JMP], target_i};
  assign pcl_pc = {latch_i[HI_PCL-1:0], alu_i};

  always_comb begin
    unique case (sel_i)
      SEL_IRQ:  nxt_o = IRQ_VEC;
      SEL_CALL: nxt_o = jmp_pc;
      SEL_JMP:  nxt_o = jmp_pc;
      SEL_RET:  nxt_o = stk_top_i;
      SEL_PCL:  nxt_o = pcl_pc;
      SEL_INC:  nxt_o = pc_inc;
      default:  nxt_o = pc_i;
    endcase
  end

  // Interrupt saves the not-yet-executed PC; a call saves the next one.
  assign push_data_o = (sel_i == SEL_IRQ) ? pc_i : pc_inc;
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] sp_dec;
  logic [W-1:0]     mem_q [DEPTH];

  assign sp_dec = sp_q - PTR_W'(1);
  assign top_o  = mem_q[sp_dec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= '0;
    else if (push_i)  sp_q <= sp_q + PTR_W'(1);
    else if (pop_i)   sp_q <= sp_dec;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (push_i && (sp_q == PTR_W'(g)))     mem_q[g] <= push_data_i;
    end
  end

  AST_NO_PUSH_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R10
  AST_PUSH_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(push_data_i)); // R5
  AST_POP_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> sp_q == PTR_W'($past(sp_q) - PTR_W'(1))); // R9
  AST_PUSH_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp_q == PTR_W'($past(sp_q) + PTR_W'(1))); // R8
endmodule

// File: rtl/pc_seq_top.sv
module pc_seq_top
  import pcs_pkg::*;
#(
  parameter int W      = PC_W,
  parameter int OW     = OPC_W,
  parameter int LW     = LAT_W,
  parameter int DW     = DATA_W,
  parameter int DEPTH  = STK_DEPTH,
  parameter int IMPL   = IMPL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          pcl_wr_i,
  input  logic          jump_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          irq_i,
  input  logic [LW-1:0] latch_i,
  input  logic [DW-1:0] alu_i,
  input  logic [OW-1:0] target_i,
  output logic [W-1:0]  pc_o,
  output logic [W-1:0]  fetch_addr_o
);
  sel_e         sel;
  logic         push;
  logic         pop;
  logic [W-1:0] pc_q;
  logic [W-1:0] pc_nxt;
  logic [W-1:0] push_data;
  logic [W-1:0] stk_top;

  pc_sel_arb u_arb (
    .inc_i    (inc_i),
    .pcl_wr_i (pcl_wr_i),
    .jump_i   (jump_i),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .irq_i    (irq_i),
    .sel_o    (sel),
    .push_o   (push),
    .pop_o    (pop)
  );

  pc_next_mux #(.W(W), .OW(OW), .LW(LW), .DW(DW)) u_mux (
    .sel_i       (sel),
    .pc_i        (pc_q),
    .latch_i     (latch_i),
    .alu_i       (alu_i),
    .target_i    (target_i),
    .stk_top_i   (stk_top),
    .nxt_o       (pc_nxt),
    .push_data_o (push_data)
  );

  pc_ret_stack #(.W(W), .DEPTH(DEPTH)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (push_data),
    .top_o       (stk_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;

  if (IMPL < W) begin : g_fold
    assign fetch_addr_o = {{(W-IMPL){1'b0}}, pc_q[IMPL-1:0]};
  end else begin : g_full
    assign fetch_addr_o = pc_q;
  end

  AST_IRQ_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> pc_o == IRQ_VEC); // R3
  AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((jump_i || call_i) && !irq_i) |=> pc_o[OW-1:0] == $past(target_i)); // R4
  AST_PCL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcl_wr_i && !(irq_i || call_i || jump_i || ret_i)) |=> pc_o[DW-1:0] == $past(alu_i)); // R7
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !(irq_i || call_i || jump_i || ret_i || pcl_wr_i))
      |=> pc_o == W'($past(pc_o) + W'(1))); // R2
  AST_FETCH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_addr_o[IMPL-1:0] == pc_o[IMPL-1:0]); // R11
endmodule

// File: tb/pc_seq_top_tb_top.sv
module pc_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inc_i = 0, pcl_wr_i = 0, jump_i = 0, call_i = 0, ret_i = 0, irq_i = 0;
  logic [4:0]  latch_i = '0;
  logic [7:0]  alu_i = '0;
  logic [10:0] target_i = '0;
  logic [12:0] pc_o, fetch_addr_o;

  pc_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .inc_i(inc_i), .pcl_wr_i(pcl_wr_i),
    .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i), .irq_i(irq_i),
    .latch_i(latch_i), .alu_i(alu_i), .target_i(target_i),
    .pc_o(pc_o), .fetch_addr_o(fetch_addr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  logic [12:0] m_pc = '0;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp = '0;

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare one expected item per cycle after the edge settles.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      logic [12:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, pc_o, e);
      check({t, " R11 fetch"}, fetch_addr_o, {2'b00, e[10:0]});
    end
  end

  task automatic model_reset();
    m_pc = '0; m_sp = '0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
  endtask

  // Driver: apply strobes for one cycle and queue the PC expected after it.
  task automatic step(input bit inc, input bit pcl, input bit jmp, input bit cal,
                      input bit ret, input bit irq, input logic [4:0] lat,
                      input logic [7:0] alu, input logic [10:0] tgt, input string tag);
    @(negedge clk);
    inc_i = inc; pcl_wr_i = pcl; jump_i = jmp; call_i = cal; ret_i = ret; irq_i = irq;
    latch_i = lat; alu_i = alu; target_i = tgt;
    if (irq) begin
      m_stk[m_sp] = m_pc; m_sp = m_sp + 3'd1; m_pc = 13'h0004;
    end else if (cal || jmp) begin
      if (cal) begin m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 3'd1; end
      m_pc = {lat[4:3], tgt};
    end else if (ret) begin
      m_sp = m_sp - 3'd1; m_pc = m_stk[m_sp];
    end else if (pcl) begin
      m_pc = {lat, alu};
    end else if (inc) begin
      m_pc = m_pc + 13'd1;
    end
    exp_q.push_back(m_pc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0,0,0,0,0,0, 5'h00, 8'h00, 11'h000, tag);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    model_reset();
    repeat (2) @(negedge clk);
    check("R1 reset pc", pc_o, 13'h0000);
    check("R11 reset fetch", fetch_addr_o, 13'h0000);
    rst_ni = 1'b1;

    step(1,0,0,0,0,0, 5'h00, 8'h00, 11'h000, "R2 inc");
    step(1,0,0,0,0,0, 5'h00, 8'h00, 11'h000, "R2 inc");
    idle("R2 hold");
    step(0,1,0,0,0,0, 5'h12, 8'h34, 11'h000, "R7 pcl write");
    step(1,0,0,0,0,0, 5'h00, 8'h00, 11'h000, "R2 inc after pcl");
    step(0,0,1,0,0,0, 5'h18, 8'h00, 11'h7FE, "R4 jump hi bits");
    step(1,0,0,0,0,0, 5'h00, 8'h00, 11'h000, "R2 inc");
    step(1,0,0,0,0,0, 5'h00, 8'h00, 11'h000, "R2 wrap to zero");
    step(0,0,0,1,0,0, 5'h07, 8'h00, 11'h100, "R5 call");
    step(1,0,0,0,0,0, 5'h00, 8'h00, 11'h000, "R2 inc in sub");
    step(0,0,0,1,0,0, 5'h08, 8'h00, 11'h200, "R5 nested call");
    step(0,0,0,0,1,0, 5'h00, 8'h00, 11'h000, "R6 return inner");
    step(0,0,0,0,1,0, 5'h00, 8'h00, 11'h000, "R6 return outer");
    step(0,0,0,0,0,1, 5'h00, 8'h00, 11'h000, "R3 irq vector");
    step(1,0,0,0,0,0, 5'h00, 8'h00, 11'h000, "R2 inc in isr");
    step(0,0,0,0,1,0, 5'h00, 8'h00, 11'h000, "R3 return from irq");

    step(0,1,1,1,1,1, 5'h1F, 8'hAA, 11'h555, "R10 irq beats all");
    step(0,0,1,1,1,0, 5'h10, 8'h00, 11'h321, "R10 call beats ret");
    step(0,0,0,0,1,0, 5'h00, 8'h00, 11'h000, "R10 pop after call");
    step(0,1,0,0,1,0, 5'h03, 8'h77, 11'h000, "R10 ret beats pcl");
    step(1,1,0,0,0,0, 5'h0A, 8'h5C, 11'h000, "R10 pcl beats inc");
    step(1,0,1,0,0,0, 5'h00, 8'h00, 11'h0AB, "R10 jump beats inc");
    step(0,0,0,0,1,0, 5'h00, 8'h00, 11'h000, "R10 jump left stack alone");

    for (int i = 0; i < 9; i++)
      step(0,0,0,1,0,0, 5'h00, 8'h00, 11'(16*i + 3), "R8 deep call");
    for (int i = 0; i < 10; i++)
      step(0,0,0,0,1,0, 5'h00, 8'h00, 11'h000, "R8 wrapped return");

    repeat (3) idle("R2 hold before reset");
    @(negedge clk);
    rst_ni = 1'b0;
    model_reset();
    #1;
    check("R1 async reset pc", pc_o, 13'h0000);
    @(negedge clk);
    rst_ni = 1'b1;
    step(0,0,0,0,1,0, 5'h00, 8'h00, 11'h000, "R9 pop on empty");
    step(0,0,0,1,0,0, 5'h08, 8'h00, 11'h444, "R9 push after underflow");
    step(0,0,0,0,1,0, 5'h00, 8'h00, 11'h000, "R9 pop same slot");
    idle("R2 final hold");
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule